// File: doc/BRIEF.md
# Two-Level Way-Predicted Instruction Cache

This block serves instruction fetches from two cache levels that hold disjoint sets of lines. A small first level (L0) and a larger second level (L1) are looked up in the same cycle. A per-set predictor names the L0 way that hit most recently. A hit in that way returns the fetch after the base one-cycle latency. A hit in any other L0 way costs one extra cycle and retrains the predictor. A line found only in L1 is returned after a fixed penalty and promoted into L0. In the same cycle the displaced L0 line is demoted into L1, so a line lives in one level at a time and the capacity seen from outside is the sum of the two.

A fetch that misses both levels sends a refill request to the next memory level. The returned word goes straight to the requester and is installed in L0. The block then requests the next sequential line into L1, but only when neither level already holds it. Every stored line carries a parity bit supplied with the refill data. A line whose parity no longer matches is invalidated on lookup, and the fetch is handled as a miss, so a clean copy is fetched again. One fetch is handled at a time, and the fetch port stays busy until any prefetch has completed.

Top module: `l0l1_icache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `ref_req_valid` are 0, and both levels are empty, so the first fetch of any line misses.
- R2: A fetch that hits L0 in the predicted way raises `rsp_valid` in the cycle after the accepting edge (latency 1), returns that line's data, and issues no refill.
- R3: A fetch that hits L0 in a way other than the predicted one has latency 2 and makes that way the prediction for its set, so a repeat fetch of the same line has latency 1.
- R4: A fetch that misses L0 and hits L1 has latency 1 + PEN_CYC (5 by default) and moves the line into L0, so a repeat fetch has latency 1 and issues no refill.
- R5: A fetch that misses both levels drives `ref_req_valid` for one cycle with `ref_req_addr` equal to the fetch address with its six line-offset bits cleared. The fetch response comes in the same cycle that `ref_rsp_valid` is high and carries `ref_rsp_data`.
- R6: After a demand refill, if line address + 1 (byte address + 64) is absent from both levels, exactly one further refill request is issued for it and its data is stored in L1. A later fetch of it then has latency 5. If the line is present in either level, no request is issued.
- R7: The two levels never hold the same line. When a line is placed into a full L0 set, the L0 victim moves to L1, and a later fetch of that victim has latency 5 with no refill. The victim is the lowest-numbered invalid way if there is one; otherwise a round-robin pointer that steps once per fill into a full set chooses it.
- R8: The stored parity bit is `ref_rsp_par` as received, and a line is good when the XOR of its 32 data bits equals that bit. A line found with bad parity in either level is invalidated, and the fetch is treated as a miss: a refill is issued and the fetch has the miss latency.
- R9: `req_ready` is 0 from the cycle after a fetch is accepted until the fetch and any prefetch it started have completed, and exactly one response pulse is produced per fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request |
| req_addr | input | 32 | Fetch byte address |
| req_ready | output | 1 | Block can accept a fetch |
| rsp_valid | output | 1 | Fetch data valid (one-cycle pulse) |
| rsp_data | output | 32 | Fetch data |
| ref_req_valid | output | 1 | Refill request to the next level (one-cycle pulse) |
| ref_req_addr | output | 32 | Line-aligned refill address |
| ref_rsp_valid | input | 1 | Refill data valid |
| ref_rsp_data | input | 32 | Refill data |
| ref_rsp_par | input | 1 | Parity bit stored with the refill data |

## Verification
Promotion of an L1 line into L0 and demotion of the L0 victim into L1 happen on the same edge, through the write ports of both arrays. The bench fills both L0 sets with demand misses and prefetches the next line into L1. It then fetches L1-resident lines into the full set. Each demoted victim is fetched next, and the check is that it comes back with the L1 latency of 5, the correct data and no refill request, while the promoted line is served from L0 with latency 1. Parity recovery is provoked in both levels by returning a line with a flipped parity bit on its first refill, then checking that the next fetch of it refetches and delivers clean data.

// File: rtl/l0l1_icache_pkg.sv
package l0l1_icache_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int LINE_BYTES = 64;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int LINE_W     = ADDR_W - OFF_W;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic  valid;
        line_t line;
        word_t data;
        logic  par;
    } ent_t;

    typedef enum logic [2:0] {
        S_IDLE, S_LOOK, S_RESP, S_PEN, S_WAIT, S_PFCHK, S_PWAIT
    } st_t;

    function automatic logic par_ok(ent_t e);
        return (^e.data) == e.par;
    endfunction

    function automatic int sets_of(int bytes, int ways);
        return bytes / (LINE_BYTES * ways);
    endfunction
endpackage

// File: rtl/l0l1_icache_bank.sv
module l0l1_icache_bank
    import l0l1_icache_pkg::*;
#(
    parameter int SETS = 2,
    parameter int WAYS = 3,
    localparam int SW = $clog2(SETS),
    localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  line_t         lk_line,
    output logic          lk_hit,
    output logic [WW-1:0] lk_way,
    output ent_t          lk_ent,
    input  line_t         pb_line,
    output logic          pb_hit,
    input  line_t         wr_line,
    output logic [WW-1:0] wr_way,
    output ent_t          wr_vict,
    input  logic          wr_en,
    input  word_t         wr_data,
    input  logic          wr_par,
    input  logic          inv_en,
    input  logic [WW-1:0] inv_way
);
    ent_t          mem [SETS][WAYS];
    logic [WW-1:0] rr;
    logic          wr_free;
    logic          wr_present;
    logic [SW-1:0] ls, ps, ws;

    assign ls = lk_line[SW-1:0];
    assign ps = pb_line[SW-1:0];
    assign ws = wr_line[SW-1:0];

    always_comb begin
        lk_hit = 1'b0; lk_way = '0; lk_ent = '0;
        pb_hit = 1'b0;
        wr_free = 1'b0; wr_way = rr; wr_present = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (mem[ls][w].valid && mem[ls][w].line == lk_line) begin
                lk_hit = 1'b1; lk_way = WW'(w); lk_ent = mem[ls][w];
            end
            if (mem[ps][w].valid && mem[ps][w].line == pb_line)
                pb_hit = 1'b1;
            if (mem[ws][w].valid && mem[ws][w].line == wr_line)
                wr_present = 1'b1;
            if (!wr_free && !mem[ws][w].valid) begin
                wr_free = 1'b1; wr_way = WW'(w);
            end
        end
        wr_vict = mem[ws][wr_way];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr <= '0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    mem[s][w].valid <= 1'b0;
        end else begin
            if (inv_en)
                mem[ls][inv_way].valid <= 1'b0;
            if (wr_en) begin
                mem[ws][wr_way] <= '{valid: 1'b1, line: wr_line, data: wr_data, par: wr_par};
                if (!wr_free)
                    rr <= (rr == WW'(WAYS - 1)) ? '0 : rr + 1'b1;
            end
        end
    end

    // R7: a line is never written into a level that already holds it
    p_no_dup_r7: assert property (@(posedge clk) disable iff (rst) wr_en |-> !wr_present);
    // R8: invalidation happens at lookup, fills later; the two never coincide
    p_port_excl_r8: assert property (@(posedge clk) disable iff (rst) !(wr_en && inv_en));
endmodule

// File: rtl/l0l1_icache_wpred.sv
module l0l1_icache_wpred #(
    parameter int SETS = 2,
    parameter int WAYS = 3,
    localparam int SW = $clog2(SETS),
    localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] rd_set,
    output logic [WW-1:0] rd_way,
    input  logic          we,
    input  logic [SW-1:0] wr_set,
    input  logic [WW-1:0] wr_way
);
    logic [WW-1:0] pred [SETS];

    assign rd_way = pred[rd_set];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) pred[s] <= '0;
        end else if (we) begin
            pred[wr_set] <= wr_way;
        end
    end

    // R3: the prediction always names an existing way
    p_pred_range_r3: assert property (@(posedge clk) disable iff (rst) rd_way <= WW'(WAYS - 1));
endmodule

// File: rtl/l0l1_icache.sv
module l0l1_icache
    import l0l1_icache_pkg::*;
#(
    parameter int L0_BYTES = 24576,
    parameter int L0_WAYS  = 3,
    parameter int L1_BYTES = 65536,
    parameter int L1_WAYS  = 8,
    parameter int PEN_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              ref_req_valid,
    output logic [ADDR_W-1:0] ref_req_addr,
    input  logic              ref_rsp_valid,
    input  logic [DATA_W-1:0] ref_rsp_data,
    input  logic              ref_rsp_par
);
    localparam int L0_SETS = sets_of(L0_BYTES, L0_WAYS);
    localparam int L1_SETS = sets_of(L1_BYTES, L1_WAYS);
    localparam int S0W = $clog2(L0_SETS);
    localparam int W0  = (L0_WAYS > 1) ? $clog2(L0_WAYS) : 1;
    localparam int W1  = (L1_WAYS > 1) ? $clog2(L1_WAYS) : 1;
    localparam int CW  = $clog2(PEN_CYC + 1);

    st_t           st;
    line_t         cur, nxt;
    word_t         hold_d;
    logic          hold_p;
    logic [CW-1:0] cnt;

    logic          l0_hit, l1_hit, l0_pb, l1_pb;
    logic [W0-1:0] l0_way, l0_wsel, pred_way;
    logic [W1-1:0] l1_way, l1_wsel;
    ent_t          l0_ent, l1_ent, l0_vict, l1_vict;
    logic          l0_ok, l1_ok, look, fast, missx, pf_go, pen_end;
    logic          fill0, demote, pf_store, l1_wr_en;
    line_t         l1_wr_line;
    word_t         l0_wr_data, l1_wr_data;
    logic          l0_wr_par, l1_wr_par, pred_we;
    logic [W0-1:0] pred_wway;
    logic          unused_bits;

    assign nxt     = cur + 1'b1;
    assign look    = (st == S_LOOK);
    assign l0_ok   = par_ok(l0_ent);
    assign l1_ok   = par_ok(l1_ent);
    assign fast    = look && l0_hit && l0_ok && (l0_way == pred_way);
    assign missx   = look && !(l0_hit && l0_ok) && !(l1_hit && l1_ok);
    assign pf_go   = (st == S_PFCHK) && !l0_pb && !l1_pb;
    assign pen_end = (st == S_PEN) && (cnt == CW'(PEN_CYC - 1));

    // L0 fill: demand refill or promotion from L1
    assign fill0      = ((st == S_WAIT) && ref_rsp_valid) || pen_end;
    assign l0_wr_data = (st == S_WAIT) ? ref_rsp_data : hold_d;
    assign l0_wr_par  = (st == S_WAIT) ? ref_rsp_par  : hold_p;

    // L1 write: victim demotion or prefetch store
    assign demote     = fill0 && l0_vict.valid;
    assign pf_store   = (st == S_PWAIT) && ref_rsp_valid;
    assign l1_wr_en   = demote || pf_store;
    assign l1_wr_line = demote ? l0_vict.line : nxt;
    assign l1_wr_data = demote ? l0_vict.data : ref_rsp_data;
    assign l1_wr_par  = demote ? l0_vict.par  : ref_rsp_par;

    assign pred_we   = fill0 || (look && l0_hit && l0_ok && (l0_way != pred_way));
    assign pred_wway = fill0 ? l0_wsel : l0_way;

    assign unused_bits = ^{req_addr[OFF_W-1:0], l1_wsel, l1_vict};

    l0l1_icache_bank #(.SETS(L0_SETS), .WAYS(L0_WAYS)) i_l0 (
        .clk(clk), .rst(rst),
        .lk_line(cur), .lk_hit(l0_hit), .lk_way(l0_way), .lk_ent(l0_ent),
        .pb_line(nxt), .pb_hit(l0_pb),
        .wr_line(cur), .wr_way(l0_wsel), .wr_vict(l0_vict),
        .wr_en(fill0), .wr_data(l0_wr_data), .wr_par(l0_wr_par),
        .inv_en(look && l0_hit && !l0_ok), .inv_way(l0_way)
    );

    l0l1_icache_bank #(.SETS(L1_SETS), .WAYS(L1_WAYS)) i_l1 (
        .clk(clk), .rst(rst),
        .lk_line(cur), .lk_hit(l1_hit), .lk_way(l1_way), .lk_ent(l1_ent),
        .pb_line(nxt), .pb_hit(l1_pb),
        .wr_line(l1_wr_line), .wr_way(l1_wsel), .wr_vict(l1_vict),
        .wr_en(l1_wr_en), .wr_data(l1_wr_data), .wr_par(l1_wr_par),
        .inv_en(look && l1_hit), .inv_way(l1_way)
    );

    l0l1_icache_wpred #(.SETS(L0_SETS), .WAYS(L0_WAYS)) i_pred (
        .clk(clk), .rst(rst),
        .rd_set(cur[S0W-1:0]), .rd_way(pred_way),
        .we(pred_we), .wr_set(cur[S0W-1:0]), .wr_way(pred_wway)
    );

    assign req_ready     = (st == S_IDLE);
    assign rsp_valid     = fast || (st == S_RESP) || pen_end || ((st == S_WAIT) && ref_rsp_valid);
    assign rsp_data      = fast ? l0_ent.data : ((st == S_WAIT) ? ref_rsp_data : hold_d);
    assign ref_req_valid = missx || pf_go;
    assign ref_req_addr  = {(missx ? cur : nxt), {OFF_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            cur <= '0;
            cnt <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (req_valid) begin
                    cur <= req_addr[ADDR_W-1:OFF_W];
                    st  <= S_LOOK;
                end
                S_LOOK: begin
                    if (l0_hit && l0_ok) begin
                        hold_d <= l0_ent.data;
                        st     <= fast ? S_IDLE : S_RESP;
                    end else if (l1_hit && l1_ok) begin
                        hold_d <= l1_ent.data;
                        hold_p <= l1_ent.par;
                        cnt    <= '0;
                        st     <= S_PEN;
                    end else begin
                        st <= S_WAIT;
                    end
                end
                S_RESP:  st <= S_IDLE;
                S_PEN: begin
                    if (pen_end) st <= S_IDLE;
                    else         cnt <= cnt + 1'b1;
                end
                S_WAIT:  if (ref_rsp_valid) st <= S_PFCHK;
                S_PFCHK: st <= pf_go ? S_PWAIT : S_IDLE;
                S_PWAIT: if (ref_rsp_valid) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // R7: the levels are disjoint at every lookup
    p_exclusive_r7: assert property (@(posedge clk) disable iff (rst) look |-> !(l0_hit && l1_hit));
    // R9: the port closes once a fetch is accepted
    p_busy_r9: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> !req_ready);
    // R9: each response is a single pulse
    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid);
    // R5: refill requests are single-cycle pulses
    p_ref_pulse_r5: assert property (@(posedge clk) disable iff (rst) ref_req_valid |=> !ref_req_valid);
    // R6: refill data only arrives while a refill is outstanding
    p_ref_rsp_r6: assert property (@(posedge clk) disable iff (rst)
        ref_rsp_valid |-> (st == S_WAIT || st == S_PWAIT));
endmodule

// File: tb/test_l0l1_icache.sv
module test_l0l1_icache;
    import l0l1_icache_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready, rsp_valid, ref_req_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [ADDR_W-1:0] ref_req_addr;
    logic              ref_rsp_valid = 1'b0;
    logic [DATA_W-1:0] ref_rsp_data = '0;
    logic              ref_rsp_par = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct { word_t d; int lat; string tag; } exp_t;
    exp_t exq[$];
    int   refq[$];
    bit   busy = 0;
    int   lat  = 0;
    bit   bad6 = 1, bad7 = 1;

    always #2.5ns clk = ~clk;

    l0l1_icache #(.L0_BYTES(384), .L0_WAYS(3), .L1_BYTES(1024), .L1_WAYS(8), .PEN_CYC(4))
    i_l0l1_icache (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .ref_req_valid(ref_req_valid), .ref_req_addr(ref_req_addr),
        .ref_rsp_valid(ref_rsp_valid), .ref_rsp_data(ref_rsp_data), .ref_rsp_par(ref_rsp_par)
    );

    function automatic word_t dat(int line);
        return 32'h5A00_0000 + word_t'(line) * 32'h0001_0003;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_ref(int line);
        refq.push_back(line);
    endtask

    task automatic fetch(int line, int exp_lat, string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exq.push_back('{dat(line), exp_lat, tag});
        req_valid = 1'b1;
        req_addr  = ADDR_W'(line) << OFF_W;
        @(posedge clk);
        #1ns req_valid = 1'b0;
        while (exq.size() != 0) @(negedge clk);
    endtask

    // monitor: latency counted from the accepting edge
    always @(posedge clk) if (req_valid && req_ready) begin busy = 1; lat = 0; end

    always @(negedge clk) begin
        if (busy) begin
            lat++;
            if (lat == 1) chk(!req_ready, "R9", "ready after accept", req_ready, 0);
            if (rsp_valid) begin
                exp_t e;
                e = exq.pop_front();
                chk(rsp_data == e.d, e.tag, "data", rsp_data, e.d);
                chk(lat == e.lat, e.tag, "latency", lat, e.lat);
                busy = 0;
            end
        end else if (rsp_valid && !rst) begin
            chk(0, "R9", "response without fetch", 1, 0);
        end
    end

    // next-level model: fixed delay, first copy of lines 6 and 7 has bad parity
    initial begin
        forever begin
            @(negedge clk);
            if (ref_req_valid && !rst) begin
                int  ln;
                bit  bad;
                ln = int'(ref_req_addr >> OFF_W);
                if (refq.size() == 0) begin
                    chk(0, "R5/R6", "unexpected refill line", ln, 0);
                end else begin
                    int e;
                    e = refq.pop_front();
                    chk(ln == e, "R5/R6", "refill line", ln, e);
                end
                bad = 0;
                if (ln == 6 && bad6) begin bad = 1; bad6 = 0; end
                if (ln == 7 && bad7) begin bad = 1; bad7 = 0; end
                repeat (3) @(posedge clk);
                #1ns;
                ref_rsp_valid = 1'b1;
                ref_rsp_data  = dat(ln);
                ref_rsp_par   = (^dat(ln)) ^ bad;
                @(posedge clk);
                #1ns ref_rsp_valid = 1'b0;
            end
        end
    end

    initial begin
        #250us;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1ns rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", rsp_valid, 0);
        chk(ref_req_valid == 1'b0, "R1", "reset refill", ref_req_valid, 0);

        // L0 set = line bit 0, L1 set = line bit 0; miss latency = 1 + model delay 3
        expect_ref(0); expect_ref(1);
        fetch(0, 4, "R1 first fetch misses");          // prefetch of line 1 into L1 (R6)
        fetch(1, 5, "R6 prefetched line from L1");     // promotion (R4)
        fetch(0, 1, "R2 predicted hit");
        fetch(1, 1, "R4 promoted line now in L0");
        expect_ref(2); expect_ref(3);
        fetch(2, 4, "R5 miss refill");
        fetch(0, 2, "R3 wrong-way hit");
        fetch(0, 1, "R3 predictor retrained");
        expect_ref(4); expect_ref(5);
        fetch(4, 4, "R5 miss fills third way");
        fetch(3, 5, "R4 L1 hit penalty");
        expect_ref(9); expect_ref(10);
        fetch(9, 4, "R5 miss fills set 1");
        fetch(10, 5, "R7 promote into full set");      // demotes line 0
        fetch(0, 5, "R7 demoted victim from L1");      // demotes line 2
        fetch(2, 5, "R7 round-robin victim");
        expect_ref(8);
        fetch(8, 4, "R6 no prefetch when next line held");
        expect_ref(6); expect_ref(7);
        fetch(6, 4, "R8 refill with bad parity");
        expect_ref(6);
        fetch(6, 4, "R8 L0 parity error refetch");
        fetch(6, 1, "R8 clean copy in L0");
        expect_ref(7);
        fetch(7, 4, "R8 L1 parity error refetch");
        fetch(9, 5, "R7 victim of parity refill");

        repeat (20) @(negedge clk);
        chk(refq.size() == 0, "R6", "outstanding expected refills", refq.size(), 0);
        chk(req_ready == 1'b1, "R9", "idle at end", req_ready, 1);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule